// File: doc/BRIEF.md
# Token-Ring Circular FIFO

This block is a first-in first-out buffer built as a ring of identical storage cells, with no central head or tail counters. Two one-hot tokens travel around the ring: the write token marks the cell that will accept the next word, and the read token marks the cell that will supply the next word. A word stays in the cell that stored it until it is read. Each cell alternates between being filled and being drained.

A producer and a consumer attach to the block through two separate ports. Each port is a shared data bus with a four-phase request/acknowledge pair. The producer holds its word steady from request rise until acknowledge rise. The consumer may take the word from acknowledge rise until it lowers its request.

When every cell holds unread data, a write request waits without an acknowledge. When no cell holds data, a read request also waits. Writes and reads to different cells may be acknowledged in the same cycle.

Top module: `token_ring_fifo`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both acknowledges are low and every cell is empty. Both tokens sit at cell 0.
- R2: The block samples a write request on a clock edge. If the cell holding the write token is empty, put_ack is high after that edge, and the word is stored at the same edge.
- R3: An acknowledge stays high while its request stays high. It goes low at the first clock edge that samples its request low. One handshake transfers exactly one word.
- R4: A read request sampled while the cell holding the read token is full raises get_ack at that edge. get_data carries the stored word from that edge and stays unchanged while get_ack stays high.
- R5: Words leave in the order they were written.
- R6: Capacity is DEPTH words. With all DEPTH cells full, a write request is not acknowledged until a read frees the cell that holds the write token. The acknowledge then comes no earlier than the edge after the freeing read.
- R7: A read request made while the buffer is empty is held without an acknowledge until a word has been written. The word then written is the one delivered.
- R8: The write token and the read token are each one-hot at all times.
- R9: A stored word never changes while its cell stays full.
- R10: A write and a read that target different cells, requested in the same cycle, are both acknowledged at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| put_req | input | 1 | Producer request, four-phase |
| put_data | input | WIDTH | Word to store; must be stable from request rise to acknowledge rise |
| put_ack | output | 1 | Producer acknowledge |
| get_req | input | 1 | Consumer request, four-phase |
| get_ack | output | 1 | Consumer acknowledge |
| get_data | output | WIDTH | Word read out; valid from acknowledge rise to request fall |

## Verification
The bench drives inputs on the falling edge and samples on the next falling edge.

- A request that finds room or data, as required, must show its acknowledge one sample later. A lowered request must show its acknowledge low one sample later.
- A write that frees a blocked read, or a read that frees a blocked write, delays the other port's acknowledge by one further cycle. The bench expects it two samples after the freeing request.
- Read data is compared at the sample where get_ack is first seen high.
- During random-timing traffic, only order and data are checked against a queue model. Latency is not checked there.

// File: rtl/tokring_pkg.sv
package tokring_pkg;

    // Phase of one four-phase port.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_ACK  = 1'b1
    } hs_phase_e;

    // Control state held by each ring cell.
    typedef struct packed {
        logic wtok;   // write token present
        logic rtok;   // read token present
        logic full;   // holds an unread word
    } cell_ctl_t;

    // Index of the upstream neighbour in the ring.
    function automatic int unsigned ring_prev(input int unsigned idx, input int unsigned depth);
        return (idx == 0) ? depth - 1 : idx - 1;
    endfunction

endpackage

// File: rtl/ring_hs_port.sv
module ring_hs_port
    import tokring_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic ready,
    output logic ack,
    output logic fire
);
    hs_phase_e phase_q;

    assign fire = req && (phase_q == PH_IDLE) && ready;
    assign ack  = (phase_q == PH_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else if (fire) begin
            phase_q <= PH_ACK;
        end else if (!req) begin
            phase_q <= PH_IDLE;
        end
    end

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ack && req) |=> ack); // R3
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (ack && !req) |=> !ack); // R3
endmodule

// File: rtl/ring_cell.sv
module ring_cell
    import tokring_pkg::*;
#(
    parameter int unsigned WIDTH   = 8,
    parameter bit          STARTER = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_fire,
    input  logic             rd_fire,
    input  logic             wtok_in,
    input  logic             rtok_in,
    input  logic [WIDTH-1:0] wdata,
    output logic             wtok,
    output logic             rtok,
    output logic             full,
    output logic [WIDTH-1:0] word
);
    cell_ctl_t        ctl_q;
    logic [WIDTH-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{wtok: STARTER, rtok: STARTER, full: 1'b0};
            word_q <= '0;
        end else begin
            if (wr_fire) begin
                ctl_q.wtok <= wtok_in;
                if (ctl_q.wtok) begin
                    word_q     <= wdata;
                    ctl_q.full <= 1'b1;
                end
            end
            if (rd_fire) begin
                ctl_q.rtok <= rtok_in;
                if (ctl_q.rtok) begin
                    ctl_q.full <= 1'b0;
                end
            end
        end
    end

    assign wtok = ctl_q.wtok;
    assign rtok = ctl_q.rtok;
    assign full = ctl_q.full;
    assign word = word_q;

    AST_CELL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.full && $past(ctl_q.full)) |-> $stable(word_q)); // R9
endmodule

// File: rtl/token_ring_fifo.sv
module token_ring_fifo
    import tokring_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             put_req,
    input  logic [WIDTH-1:0] put_data,
    output logic             put_ack,
    input  logic             get_req,
    output logic             get_ack,
    output logic [WIDTH-1:0] get_data
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] wtok_v, rtok_v, full_v;
    logic [WIDTH-1:0] word_a [DEPTH];
    logic             wr_fire, rd_fire, wr_ready, rd_ready;
    logic [WIDTH-1:0] rd_word, rdata_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam int unsigned PREV = ring_prev(i, DEPTH);
        ring_cell #(.WIDTH(WIDTH), .STARTER(i == 0)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .wr_fire (wr_fire),
            .rd_fire (rd_fire),
            .wtok_in (wtok_v[PREV]),
            .rtok_in (rtok_v[PREV]),
            .wdata   (put_data),
            .wtok    (wtok_v[i]),
            .rtok    (rtok_v[i]),
            .full    (full_v[i]),
            .word    (word_a[i])
        );
    end

    assign wr_ready = |(wtok_v & ~full_v);
    assign rd_ready = |(rtok_v & full_v);

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rtok_v[i]) rd_word = rd_word | word_a[i];
        end
    end

    ring_hs_port u_put_port (
        .clk(clk), .rst(rst), .req(put_req), .ready(wr_ready),
        .ack(put_ack), .fire(wr_fire)
    );

    ring_hs_port u_get_port (
        .clk(clk), .rst(rst), .req(get_req), .ready(rd_ready),
        .ack(get_ack), .fire(rd_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_fire) begin
            rdata_q <= rd_word;
        end
    end

    assign get_data = rdata_q;

    AST_WTOK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot(wtok_v)); // R8
    AST_RTOK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot(rtok_v)); // R8
    AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $rose(get_ack) |-> (CNT_W'($countones($past(full_v))) != '0)); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (get_ack && $past(get_ack)) |-> $stable(get_data)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (&full_v) |=> !$rose(put_ack)); // R6
endmodule

// File: tb/tb_token_ring_fifo.sv
module tb_token_ring_fifo;
    localparam int DEPTH = 4;
    localparam int WIDTH = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             put_req = 1'b0;
    logic [WIDTH-1:0] put_data = '0;
    logic             put_ack;
    logic             get_req = 1'b0;
    logic             get_ack;
    logic [WIDTH-1:0] get_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [WIDTH-1:0] model_q [$];

    always #2.5 clk = ~clk;

    token_ring_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .clk(clk), .rst(rst), .put_req(put_req), .put_data(put_data), .put_ack(put_ack),
        .get_req(get_req), .get_ack(get_ack), .get_data(get_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Raise put_req, wait for put_ack; exp_lat < 0 skips the latency check.
    task automatic do_put(input logic [WIDTH-1:0] d, input int exp_lat, input string req);
        int n = 0;
        @(negedge clk);
        put_data = d;
        put_req  = 1'b1;
        do begin @(negedge clk); n++; end while (!put_ack && n < 200);
        if (exp_lat >= 0) chk(n == exp_lat, req, n, exp_lat);
        model_q.push_back(d);
        put_req = 1'b0;
        @(negedge clk);
        chk(put_ack == 1'b0, "R3 put_ack release", int'(put_ack), 0);
    endtask

    task automatic do_get(input int exp_lat, input string req);
        int n = 0;
        logic [WIDTH-1:0] e;
        @(negedge clk);
        get_req = 1'b1;
        do begin @(negedge clk); n++; end while (!get_ack && n < 200);
        if (exp_lat >= 0) chk(n == exp_lat, req, n, exp_lat);
        e = (model_q.size() > 0) ? model_q.pop_front() : '0;
        chk(get_data == e, "R5 order/data", int'(get_data), int'(e));
        @(negedge clk);
        chk(get_data == e, "R4 data held", int'(get_data), int'(e));
        get_req = 1'b0;
        @(negedge clk);
        chk(get_ack == 1'b0, "R3 get_ack release", int'(get_ack), 0);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk(put_ack == 1'b0 && get_ack == 1'b0, "R1 acks in reset", int'({put_ack, get_ack}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(put_ack == 1'b0 && get_ack == 1'b0, "R1 acks after reset", int'({put_ack, get_ack}), 0);

        // R7: read on empty is held, then served by the next write
        get_req = 1'b1;
        repeat (5) @(negedge clk);
        chk(get_ack == 1'b0, "R7 empty read held", int'(get_ack), 0);
        put_data = 8'hA5;
        put_req  = 1'b1;
        @(negedge clk);
        chk(put_ack == 1'b1, "R2 put latency", int'(put_ack), 1);
        chk(get_ack == 1'b0, "R7 not yet", int'(get_ack), 0);
        put_req = 1'b0;
        @(negedge clk);
        chk(get_ack == 1'b1, "R7 read after write", int'(get_ack), 1);
        chk(get_data == 8'hA5, "R7 data", int'(get_data), 8'hA5);
        get_req = 1'b0;
        @(negedge clk);
        chk(get_ack == 1'b0 && put_ack == 1'b0, "R3 both released", int'({put_ack, get_ack}), 0);

        // R2/R6: fill to capacity, then the extra write blocks
        for (int i = 0; i < DEPTH; i++) do_put(8'(8'h10 + i * 3), 1, "R2 put latency");
        @(negedge clk);
        put_data = 8'hEE;
        put_req  = 1'b1;
        repeat (6) @(negedge clk);
        chk(put_ack == 1'b0, "R6 full write held", int'(put_ack), 0);
        get_req = 1'b1;
        @(negedge clk);
        chk(get_ack == 1'b1, "R4 get latency", int'(get_ack), 1);
        chk(get_data == model_q[0], "R5 first word", int'(get_data), int'(model_q[0]));
        chk(put_ack == 1'b0, "R6 not same edge", int'(put_ack), 0);
        void'(model_q.pop_front());
        get_req = 1'b0;
        @(negedge clk);
        chk(put_ack == 1'b1, "R6 write after free", int'(put_ack), 1);
        model_q.push_back(8'hEE);
        put_req = 1'b0;
        @(negedge clk);

        // R10: concurrent write and read to different cells
        put_data = 8'h5C;
        put_req  = 1'b0;
        do_get(1, "R4 get latency");
        @(negedge clk);
        put_data = 8'h5C;
        put_req  = 1'b1;
        get_req  = 1'b1;
        @(negedge clk);
        chk(put_ack == 1'b1 && get_ack == 1'b1, "R10 both acked", int'({put_ack, get_ack}), 3);
        chk(get_data == model_q[0], "R5 concurrent data", int'(get_data), int'(model_q[0]));
        void'(model_q.pop_front());
        model_q.push_back(8'h5C);
        put_req = 1'b0;
        get_req = 1'b0;
        @(negedge clk);

        // R5/R9: drain, then random-timing traffic against the queue model
        while (model_q.size() > 0) do_get(1, "R4 get latency");
        fork
            begin
                for (int k = 0; k < 80; k++) begin
                    repeat ($urandom_range(0, 3)) @(negedge clk);
                    do_put(8'($urandom), -1, "R2");
                end
            end
            begin
                for (int k = 0; k < 80; k++) begin
                    repeat ($urandom_range(0, 4)) @(negedge clk);
                    do_get(-1, "R5");
                end
            end
        join
        chk(model_q.size() == 0, "R5 model drained", model_q.size(), 0);
        @(negedge clk);
        get_req = 1'b1;
        repeat (4) @(negedge clk);
        chk(get_ack == 1'b0, "R7 empty after drain", int'(get_ack), 0);
        get_req = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule